// File: doc/BRIEF.md
# Transition Density Fault Detector

This block sits after a deserializer and looks at the received serial stream one 10-bit character at a time, with one character per character clock. It watches how long the line has gone without a change of bit value, and it counts the gaps across character boundaries as well as inside each character. When the stream stays at one level for too long, the block drops its density-ok flag. The flag comes back only when the stream again has a transition in each of several characters in a row. This lets a link monitor tell a dead or stuck line apart from a live one. Setting the fault is quick and clearing it is slow, so the flag does not toggle on marginal data.

Inside a character, bit 0 is the first bit in time and bit 9 is the last. The block keeps the last bit of the previous accepted character so that it can see a change at the character boundary. It measures the current run of identical bits in bit times; the counter stops rising at one more than the limit. A small state machine with three states drives the flag:

- FAULT: the flag is low.
- RECOVER: the flag is low and at least one good character has been seen.
- OK: the flag is high.

The transitions are named as follows:

- good_first: FAULT to RECOVER.
- good_more: RECOVER stays in RECOVER with its count advanced.
- good_done: RECOVER to OK, or FAULT to OK when only one good character is needed.
- bad_restart: RECOVER to FAULT.
- run_overflow: OK to FAULT.

Top module: `tdf_monitor`

## Requirements
- R1: While reset is asserted, and directly after it, `density_ok` is 0. The state is FAULT, and the run length and stored-bit history are cleared.
- R2: `density_ok` goes to 1 in the cycle after the third consecutive accepted character that contains a transition. Each of these characters takes the path FAULT→RECOVER→RECOVER→OK.
- R3: A character contains a transition if any two bits that are neighbours in time differ. Bit 0 is compared with the previous accepted character's bit 9, and bit i is compared with bit i−1 for i from 1 to 9.
- R4: In state OK, the fault sets once more than 60 consecutive bit times pass without a transition (run_overflow). A run of exactly 60 keeps `density_ok` at 1, and a run of 61 clears it in the cycle after the character that completes the run.
- R5: In RECOVER, an accepted character with no transition returns the block to FAULT and restarts the count of good characters (bad_restart).
- R6: A cycle with `char_valid` at 0 has no effect. It does not change the run length, the stored last bit, the good-character count, the state or `density_ok`.
- R7: The run-length counter stops rising at 61. Any length of constant stream keeps the fault set, and three good characters afterwards still recover the block normally.
- R8: A character whose only transition lies at the boundary with the previous character counts as a good character. After such a character, the run length equals the full character width.
- R9: The first accepted character after reset has no previous bit, so no transition is counted at its leading boundary. A constant first character is therefore not good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | The character on `char_data` is accepted this cycle |
| char_data | input | 10 | Received character; bit 0 is earliest in time |
| density_ok | output | 1 | 1 while transition density is adequate |

## Verification
The run-length update and the recovery count act on the same character. A constant character in RECOVER must both lengthen the run and send the machine back to FAULT. A boundary-only character must both set the run to exactly ten and count toward recovery. The bench provokes both cases: it builds runs of exactly 60 and 61 bits by choosing where the last transition sits, and it feeds alternating constant characters into a saturated fault. It also places idle cycles carrying transition-rich data just before a run would overflow, and judges from the output that these cycles did not reset the run. Every cycle, a behavioural bit-by-bit model predicts the flag, and the bench compares it with the block's output.

// File: rtl/tdf_pkg.sv
package tdf_pkg;
    typedef enum logic [1:0] {
        ST_FAULT   = 2'd0,
        ST_RECOVER = 2'd1,
        ST_OK      = 2'd2
    } tdf_state_e;
endpackage

// File: rtl/tdf_edge_scan.sv
// Finds bit transitions in one character, including the leading boundary,
// and reports how long the trailing run of equal bits is.
module tdf_edge_scan #(
    parameter int CHAR_W = 10,
    parameter int RUN_W  = 7
) (
    input  logic [CHAR_W-1:0] data,
    input  logic              prev_bit,
    input  logic              prev_seen,
    output logic              any_edge,
    output logic [RUN_W-1:0]  tail_run
);
    logic [CHAR_W-1:0] edges;

    assign edges[0] = prev_seen & (data[0] ^ prev_bit);

    genvar gi;
    generate
        for (gi = 1; gi < CHAR_W; gi++) begin : g_edge
            assign edges[gi] = data[gi] ^ data[gi-1];
        end
    endgenerate

    assign any_edge = |edges;

    // The last transition in time decides the trailing run length.
    always_comb begin
        tail_run = '0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (edges[i]) begin
                tail_run = RUN_W'(CHAR_W - i);
            end
        end
    end
endmodule

// File: rtl/tdf_run_track.sv
// Holds the run length in bit times and the last accepted bit.
module tdf_run_track #(
    parameter int CHAR_W  = 10,
    parameter int RUN_W   = 7,
    parameter int RUN_CAP = 61
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic              last_bit_in,
    input  logic              any_edge,
    input  logic [RUN_W-1:0]  tail_run,
    output logic [RUN_W-1:0]  run_next,
    output logic [RUN_W-1:0]  run_q,
    output logic              prev_bit_q,
    output logic              prev_seen_q
);
    logic [RUN_W:0] sum;

    always_comb begin
        sum = {1'b0, run_q} + (RUN_W+1)'(CHAR_W);
        if (any_edge) begin
            run_next = tail_run;
        end else if (sum > (RUN_W+1)'(RUN_CAP)) begin
            run_next = RUN_W'(RUN_CAP);
        end else begin
            run_next = sum[RUN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= '0;
            prev_bit_q  <= 1'b0;
            prev_seen_q <= 1'b0;
        end else if (char_valid) begin
            run_q       <= run_next;
            prev_bit_q  <= last_bit_in;
            prev_seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/tdf_fsm.sv
// Fault / recover / ok machine with an asymmetric hysteresis.
module tdf_fsm
    import tdf_pkg::*;
#(
    parameter int GOOD_CHARS = 3,
    parameter int CNT_W      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic char_valid,
    input  logic good_char,
    input  logic run_over,
    output logic density_ok
);
    tdf_state_e             state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(GOOD_CHARS - 1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FAULT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (char_valid) begin
            unique case (state_q)
                ST_FAULT: begin
                    if (good_char) begin
                        if (GOOD_CHARS <= 1) begin
                            state_d = ST_OK;          // good_done
                            cnt_d   = '0;
                        end else begin
                            state_d = ST_RECOVER;     // good_first
                            cnt_d   = CNT_W'(1);
                        end
                    end
                end
                ST_RECOVER: begin
                    if (!good_char) begin
                        state_d = ST_FAULT;           // bad_restart
                        cnt_d   = '0;
                    end else if (cnt_q == LAST_CNT) begin
                        state_d = ST_OK;              // good_done
                        cnt_d   = '0;
                    end else begin
                        cnt_d   = cnt_q + CNT_W'(1);  // good_more
                    end
                end
                ST_OK: begin
                    if (run_over) begin
                        state_d = ST_FAULT;           // run_overflow
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = ST_FAULT;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Output
    always_comb begin
        density_ok = (state_q == ST_OK);
    end
endmodule

// File: rtl/tdf_monitor.sv
module tdf_monitor #(
    parameter int CHAR_W     = 10,
    parameter int MAX_RUN    = 60,
    parameter int GOOD_CHARS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_data,
    output logic              density_ok
);
    localparam int RUN_CAP = MAX_RUN + 1;
    localparam int RUN_W   = $clog2(RUN_CAP + CHAR_W + 1);
    localparam int CNT_W   = (GOOD_CHARS < 2) ? 1 : $clog2(GOOD_CHARS);

    logic             any_edge;
    logic [RUN_W-1:0] tail_run;
    logic [RUN_W-1:0] run_next;
    logic [RUN_W-1:0] run_len_q;
    logic             prev_bit_q;
    logic             prev_seen_q;

    tdf_edge_scan #(.CHAR_W(CHAR_W), .RUN_W(RUN_W)) u_scan (
        .data      (char_data),
        .prev_bit  (prev_bit_q),
        .prev_seen (prev_seen_q),
        .any_edge  (any_edge),
        .tail_run  (tail_run)
    );

    tdf_run_track #(.CHAR_W(CHAR_W), .RUN_W(RUN_W), .RUN_CAP(RUN_CAP)) u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .char_valid  (char_valid),
        .last_bit_in (char_data[CHAR_W-1]),
        .any_edge    (any_edge),
        .tail_run    (tail_run),
        .run_next    (run_next),
        .run_q       (run_len_q),
        .prev_bit_q  (prev_bit_q),
        .prev_seen_q (prev_seen_q)
    );

    tdf_fsm #(.GOOD_CHARS(GOOD_CHARS), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_valid (char_valid),
        .good_char  (any_edge),
        .run_over   (run_next > RUN_W'(MAX_RUN)),
        .density_ok (density_ok)
    );
endmodule

// File: rtl/tdf_monitor_sva.sv
module tdf_monitor_sva #(
    parameter int MAX_RUN = 60,
    parameter int RUN_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             char_valid,
    input logic             density_ok,
    input logic [RUN_W-1:0] run_len
);
    a_r1_reset_fault: assert property (@(posedge clk)
        !rst_n |-> !density_ok);

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !char_valid |=> $stable(density_ok));

    a_r2_rise_needs_char: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(density_ok) |-> $past(char_valid));

    a_r4_fall_needs_char: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(density_ok) |-> $past(char_valid));

    a_r4_long_run_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (run_len > RUN_W'(MAX_RUN)) |-> !density_ok);

    a_r7_run_capped: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= RUN_W'(MAX_RUN + 1));
endmodule

bind tdf_monitor tdf_monitor_sva #(.MAX_RUN(MAX_RUN), .RUN_W(RUN_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_valid (char_valid),
    .density_ok (density_ok),
    .run_len    (run_len_q)
);

// File: tb/tdf_monitor_test.sv
module tdf_monitor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       char_valid = 1'b0;
    logic [9:0] char_data = '0;
    logic       density_ok;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int m_run = 0;
    bit m_prev = 0;
    bit m_have = 0;
    int m_good = 0;
    bit m_ok = 0;

    always #2.5 clk = ~clk;

    tdf_monitor uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_valid (char_valid),
        .char_data  (char_data),
        .density_ok (density_ok)
    );

    task automatic model_step(input logic [9:0] d);
        bit trans = 0;
        for (int i = 0; i < 10; i++) begin
            if (m_have && d[i] != m_prev) begin
                trans = 1;
                m_run = 1;
            end else begin
                m_run = m_run + 1;
                if (m_run > 61) m_run = 61;
            end
            m_prev = d[i];
            m_have = 1;
        end
        if (!m_ok) begin
            if (trans) begin
                m_good = m_good + 1;
                if (m_good >= 3) begin
                    m_ok = 1;
                    m_good = 0;
                end
            end else begin
                m_good = 0;
            end
        end else if (m_run > 60) begin
            m_ok = 0;
            m_good = 0;
        end
    endtask

    task automatic check(input bit exp, input string tag);
        checks++;
        if (density_ok !== exp) begin
            errors++;
            $display("FAIL %s: density_ok actual %b expected %b", tag, density_ok, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic send(input logic v, input logic [9:0] d, input string tag);
        char_valid = v;
        char_data  = d;
        if (v) model_step(d);
        @(posedge clk);
        @(negedge clk);
        check(m_ok, tag);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R1 after reset");

        // R9: constant first character is not good
        send(1, 10'h3FF, "R9 first char");
        send(1, 10'h155, "R2 good 1");
        send(1, 10'h155, "R2 good 2");
        check(1'b0, "R9 only two good so far");
        send(1, 10'h155, "R2 good 3");
        check(1'b1, "R2 ok after three");

        // R3/R4: 51 bits, then a char whose only change is at bit 9
        for (int k = 0; k < 5; k++) send(1, 10'h000, "R4 run build");
        check(1'b1, "R4 run 51");
        send(1, 10'h200, "R3 edge at bit9");
        check(1'b1, "R3 late edge resets run");
        for (int k = 0; k < 5; k++) send(1, 10'h3FF, "R4 run build 2");
        check(1'b1, "R4 run 51 after bit9 edge");
        send(1, 10'h3FF, "R4 run 61");
        check(1'b0, "R4 fault at 61");

        // R5: constant char during recovery restarts count
        send(1, 10'h155, "R5 good 1");
        send(1, 10'h155, "R5 good 2");
        send(1, 10'h000, "R5 bad restart");
        send(1, 10'h155, "R5 good 1 again");
        send(1, 10'h155, "R5 good 2 again");
        check(1'b0, "R5 still fault");
        send(1, 10'h155, "R5 good 3");
        check(1'b1, "R5 recovered");

        // R8/R4: boundary-only char gives run 10, then exactly 60
        send(1, 10'h3FF, "R8 boundary only");
        for (int k = 0; k < 5; k++) send(1, 10'h3FF, "R4 run to 60");
        check(1'b1, "R4 run 60 keeps ok");
        send(1, 10'h3FF, "R4 run 70");
        check(1'b0, "R4 fault past 60");

        // R7: saturated run, then boundary-only recovery (R8)
        for (int k = 0; k < 20; k++) send(1, 10'h3FF, "R7 saturated");
        check(1'b0, "R7 fault held");
        send(1, 10'h000, "R8 recover 1");
        send(1, 10'h3FF, "R8 recover 2");
        send(1, 10'h000, "R8 recover 3");
        check(1'b1, "R7 recovered after saturation");

        // R6: idle cycles with transition-rich data must not reset the run
        for (int k = 0; k < 4; k++) send(1, 10'h000, "R6 run to 50");
        for (int k = 0; k < 3; k++) send(0, 10'h155, "R6 idle");
        check(1'b1, "R6 idle no change");
        send(1, 10'h000, "R6 run 60");
        check(1'b1, "R6 run 60");
        send(1, 10'h000, "R6 run 70");
        check(1'b0, "R6 idle ignored so run overflowed");
        for (int k = 0; k < 5; k++) send(0, 10'h155, "R6 idle in fault");
        check(1'b0, "R6 idle not counted as good");
        for (int k = 0; k < 3; k++) send(1, 10'h155, "R2 recover");
        check(1'b1, "R2 recover after idle");

        // mixed stream compared to the model every cycle
        for (int k = 0; k < 3000; k++) begin
            int sel = $urandom_range(0, 9);
            logic [9:0] d;
            if (sel < 4)      d = 10'h000;
            else if (sel < 7) d = 10'h3FF;
            else              d = 10'($urandom);
            send(($urandom_range(0, 9) != 0), d, "R3 mixed stream");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule